// File: doc/BRIEF.md
# Sampling Converter Serial Result Port

This block is the digital serial port of a 16-bit sampling converter. A conversion strobe and a serial clock come in from outside the chip and are brought into the system clock domain. A rising strobe edge starts a conversion that lasts a fixed, parameterised number of system clocks. While the conversion runs, a busy flag is high. At the end of the conversion the block takes the parallel result from a converter core; in this project the testbench plays the core. If the strobe is still high at that point, the port sleeps.

When the strobe goes low, the port enters its sample phase and enables the serial data line, with the most significant result bit already presented. Each falling serial clock edge then moves the line to the next lower bit, so a receiver can capture on rising edges. Once the whole word has gone out, further clocks shift out zeros for as long as they keep coming. High impedance is modelled by a separate output-enable. The current phase is reported as a 2-bit code.

Top module: `adc_serial_port`

## Requirements
- R1: A rising strobe edge, taken after a two-stage synchroniser, puts the port into the converting phase (code 0). Busy is then high for exactly CONV_CYCLES system clocks, and the output-enable stays low.
- R2: If the strobe is still high when the conversion ends, the phase becomes sleeping (code 1) with the output disabled, and it stays there until the strobe falls.
- R3: A strobe falling edge while sleeping moves the port to sampling (code 2) with the output enabled. The data line then carries bit 15 of the result word that was present on the result input in the last converting cycle.
- R4: Once the synchronised strobe has been high for two consecutive system clocks, the output-enable is low.
- R5: In sampling or shifting, each falling serial clock edge moves the data line to the next lower bit, MSB first, and sets the phase to shifting (code 3). Rising serial clock edges change nothing.
- R6: After 16 falling edges, the data line stays 0 for every further falling edge while the strobe stays low.
- R7: A rising strobe edge during a transfer aborts it, disables the output and starts a new conversion of full length.
- R8: A strobe that falls while a conversion is running does not cut the conversion short. When the conversion ends, the port goes straight to sampling and never enters sleeping.
- R9: Falling serial clock edges in the converting or sleeping phases are ignored: the first bit presented afterwards is still bit 15.
- R10: After reset, the phase is sampling, busy is 0, the data line is 0, and the output-enable is 1 while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Conversion strobe, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| result_i | input | RES_W | Parallel result from the converter core |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Serial data enable; 0 models high impedance |
| busy_o | output | 1 | High while converting |
| phase_o | output | 2 | 0 converting, 1 sleeping, 2 sampling, 3 shifting |

## Verification
Some properties are checked on every cycle. The output stays disabled while the strobe is settled high. Sleeping only occurs with the strobe high. The conversion counter steps down by one each cycle. The shift register holds still without a serial clock fall and fills with zeros from the bottom. Other behaviour only the bench scenarios can show: the exact conversion length, the MSB-first bit order matched against random words, the ignored clocks in sleep, the early strobe fall, and the abort of a transfer by a new strobe.

// File: rtl/adc_port_pkg.sv
`timescale 1ns/1ps
package adc_port_pkg;
  typedef enum logic [1:0] {
    PH_CONVERT = 2'd0,
    PH_SLEEP   = 2'd1,
    PH_SAMPLE  = 2'd2,
    PH_SHIFT   = 2'd3
  } phase_t;

  function automatic logic edge_up(input logic now_v, input logic old_v);
    return now_v & ~old_v;
  endfunction

  function automatic logic edge_down(input logic now_v, input logic old_v);
    return ~now_v & old_v;
  endfunction

  function automatic logic drives_line(input phase_t ph);
    return (ph == PH_SAMPLE) || (ph == PH_SHIFT);
  endfunction
endpackage

// File: rtl/adc_port_sync.sv
`timescale 1ns/1ps
module adc_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      prev_o <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_i};
      prev_o <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
endmodule

// File: rtl/adc_port_sequencer.sv
`timescale 1ns/1ps
module adc_port_sequencer
  import adc_port_pkg::*;
#(
  parameter int CONV_CYCLES = 40
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   conv_level,
  input  logic   conv_prev,
  input  logic   conv_rise,
  input  logic   conv_fall,
  input  logic   sck_fall,
  output phase_t phase,
  output logic   busy,
  output logic   load_result
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] remain;
  phase_t        phase_nx;

  assign load_result = (phase == PH_CONVERT) && (remain == '0) && !conv_rise;
  assign busy        = (phase == PH_CONVERT);

  always_comb begin
    phase_nx = phase;
    if (conv_rise) begin
      phase_nx = PH_CONVERT;
    end else begin
      case (phase)
        PH_CONVERT: if (remain == '0) phase_nx = conv_level ? PH_SLEEP : PH_SAMPLE;
        PH_SLEEP:   if (conv_fall)    phase_nx = PH_SAMPLE;
        PH_SAMPLE:  if (sck_fall)     phase_nx = PH_SHIFT;
        default:    phase_nx = phase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_SAMPLE;
      remain <= '0;
    end else begin
      phase <= phase_nx;
      if (conv_rise)                                  remain <= LAST;
      else if (phase == PH_CONVERT && remain != '0)   remain <= remain - 1'b1;
    end
  end

  // R1: conversion counter steps down by exactly one per cycle
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONVERT && !conv_rise && remain != '0) |=> (remain == $past(remain) - 1'b1));

  // R2: sleeping is only reachable while the strobe was held high
  a_r2_sleep_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SLEEP) |-> conv_prev);

  // R8: a conversion ending with the strobe low never lands in sleep
  a_r8_no_sleep_low: assert property (@(posedge clk) disable iff (!rst_n)
    (load_result && !conv_level) |=> (phase == PH_SAMPLE));
endmodule

// File: rtl/adc_port_shifter.sv
`timescale 1ns/1ps
module adc_port_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word_i,
  input  logic         step,
  output logic         bit_o
);
  logic [W-1:0] sreg;

  function automatic logic [W-1:0] drop_msb(input logic [W-1:0] w);
    return {w[W-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sreg <= '0;
    else if (load) sreg <= word_i;
    else if (step) sreg <= drop_msb(sreg);
  end

  assign bit_o = sreg[W-1];

  // R5: register only moves on a load or a serial clock step
  a_r5_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(sreg));

  // R6: zeros enter from the bottom on every step
  a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> !sreg[0]);
endmodule

// File: rtl/adc_serial_port.sv
`timescale 1ns/1ps
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int RES_W       = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_i,
  input  logic             sck_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             busy_o,
  output logic [1:0]       phase_o
);
  logic   conv_level, conv_prev, sck_level, sck_prev;
  logic   conv_rise, conv_fall, sck_fall;
  logic   load_result, shift_step;
  phase_t phase;

  adc_port_sync #(.STAGES(SYNC_STAGES)) u_conv_sync (
    .clk(clk), .rst_n(rst_n), .async_i(conv_i),
    .level_o(conv_level), .prev_o(conv_prev));

  adc_port_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sck_i),
    .level_o(sck_level), .prev_o(sck_prev));

  assign conv_rise  = edge_up(conv_level, conv_prev);
  assign conv_fall  = edge_down(conv_level, conv_prev);
  assign sck_fall   = edge_down(sck_level, sck_prev);
  assign shift_step = sck_fall && drives_line(phase) && !conv_rise;

  adc_port_sequencer #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .conv_level(conv_level), .conv_prev(conv_prev),
    .conv_rise(conv_rise), .conv_fall(conv_fall), .sck_fall(sck_fall),
    .phase(phase), .busy(busy_o), .load_result(load_result));

  adc_port_shifter #(.W(RES_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_result), .word_i(result_i),
    .step(shift_step), .bit_o(sdo_o));

  assign sdo_oe_o = drives_line(phase);
  assign phase_o  = phase;

  // R4: a settled-high strobe keeps the line released
  a_r4_released_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_level && conv_prev) |-> !sdo_oe_o);

  // R7: a strobe rise always leads into converting with busy set
  a_r7_rise_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rise |=> (busy_o && !sdo_oe_o));
endmodule

// File: tb/adc_serial_port_bench.sv
`timescale 1ns/1ps
module adc_serial_port_bench;
  localparam int W    = 16;
  localparam int CONV = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv_i = 1'b0;
  logic         sck_i = 1'b0;
  logic [W-1:0] result_i = '0;
  logic         sdo_o, sdo_oe_o, busy_o;
  logic [1:0]   phase_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_serial_port #(.RES_W(W), .CONV_CYCLES(CONV)) u_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .sck_i(sck_i),
    .result_i(result_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .busy_o(busy_o), .phase_o(phase_o));

  function automatic logic bit_at(input logic [W-1:0] word, input int k);
    if (k < W) return word[W-1-k];
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulse();
    sck_i = 1'b1; wait_clks(4);
    sck_i = 1'b0; wait_clks(4);
  endtask

  // raises strobe, counts busy cycles; optionally drops strobe early
  task automatic convert(input logic [W-1:0] word, input int drop_after, output int busy_n, output bit saw_sleep);
    int idle = 0;
    busy_n = 0; saw_sleep = 1'b0;
    result_i = word;
    conv_i = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (drop_after > 0 && i == drop_after) conv_i = 1'b0;
      if (busy_o) busy_n++;
      if (phase_o == 2'd1) saw_sleep = 1'b1;
      if (busy_n > 0 && !busy_o) begin
        idle++;
        if (idle > 6) break;
      end
    end
  endtask

  task automatic read_bits(input logic [W-1:0] word, input int first, input int n);
    for (int k = first; k < first + n; k++) begin
      check(sdo_oe_o == 1'b1, (k < W) ? "R5 oe" : "R6 oe", sdo_oe_o, 1);
      check(sdo_o == bit_at(word, k), (k < W) ? "R5 bit" : "R6 zero", sdo_o, bit_at(word, k));
      sck_pulse();
      check(phase_o == 2'd3, "R5 phase", phase_o, 3);
    end
  endtask

  initial begin : main
    int bn;
    bit sl;
    logic [W-1:0] w;
    void'($urandom(32'h5EED_0042));
    wait_clks(3);
    check(phase_o == 2'd2, "R10 phase", phase_o, 2);
    check(busy_o == 1'b0, "R10 busy", busy_o, 0);
    check(sdo_o == 1'b0, "R10 sdo", sdo_o, 0);
    rst_n = 1'b1;
    wait_clks(3);
    check(sdo_oe_o == 1'b1, "R10 oe", sdo_oe_o, 1);

    // directed: sleep path, ignored clocks, full word plus zeros
    w = 16'hA5C3;
    convert(w, 0, bn, sl);
    check(bn == CONV, "R1 busy length", bn, CONV);
    check(phase_o == 2'd1, "R2 sleeping", phase_o, 1);
    check(sdo_oe_o == 1'b0, "R4 oe low in sleep", sdo_oe_o, 0);
    sck_pulse(); sck_pulse();
    check(phase_o == 2'd1, "R2 still sleeping", phase_o, 1);
    conv_i = 1'b0; wait_clks(4);
    check(phase_o == 2'd2, "R3 sampling", phase_o, 2);
    check(sdo_oe_o == 1'b1, "R3 oe", sdo_oe_o, 1);
    check(sdo_o == w[15], "R9 msb after ignored clocks", sdo_o, w[15]);
    read_bits(w, 0, W + 4);

    // directed: extremes of the code range
    w = 16'hFFFF;
    convert(w, 0, bn, sl);
    conv_i = 1'b0; wait_clks(4);
    read_bits(w, 0, W + 1);
    w = 16'h0000;
    convert(w, 0, bn, sl);
    conv_i = 1'b0; wait_clks(4);
    read_bits(w, 0, 3);

    // directed: early strobe fall
    w = 16'h1234;
    convert(w, 5, bn, sl);
    check(bn == CONV, "R8 full length", bn, CONV);
    check(sl == 1'b0, "R8 no sleep", sl, 0);
    check(phase_o == 2'd2, "R8 sampling", phase_o, 2);
    read_bits(w, 0, 6);

    // directed: abort mid-transfer
    conv_i = 1'b1; wait_clks(4);
    check(sdo_oe_o == 1'b0, "R7 oe off", sdo_oe_o, 0);
    check(phase_o == 2'd0 && busy_o, "R7 converting", phase_o, 0);
    check(sdo_oe_o == 1'b0, "R4 oe low strobe high", sdo_oe_o, 0);
    conv_i = 1'b0;
    w = 16'h8001;
    result_i = w;
    wait_clks(CONV + 4);
    check(phase_o == 2'd2, "R7 new result ready", phase_o, 2);
    read_bits(w, 0, W);

    // random mix
    for (int it = 0; it < 8; it++) begin
      w = W'($urandom);
      if ($urandom % 2) begin
        convert(w, 0, bn, sl);
        check(bn == CONV, "R1 random busy", bn, CONV);
        if ($urandom % 2) sck_pulse();
        conv_i = 1'b0; wait_clks(4);
      end else begin
        convert(w, 1 + int'($urandom % 10), bn, sl);
        check(sl == 1'b0, "R8 random no sleep", sl, 0);
      end
      read_bits(w, 0, 4 + int'($urandom % 16));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule